// File: doc/BRIEF.md
# Data Tenure Termination Controller

This controller sits on the master side of a pipelined processor bus and follows a single data tenure from its start to its end. A start pulse hands it the number of beats and whether the tenure reads or writes. From then on it watches four termination inputs from the bus: transfer acknowledge, data retry, transfer error and address retry. It drives a data-bus-busy output and a per-beat data-valid strobe to the core. It also produces a completion pulse, or an error pulse that is steered to a machine-check output or a checkstop output.

On reads, the cycle after each acknowledge is a check window. A data retry in that window voids the beat just acknowledged, and a transfer error in that window is still accepted. For this reason a read beat reaches the core only after its window has passed cleanly. The final read beat's window falls in the cycle where busy is already low. A retry there keeps the tenure alive with busy low until the slave acknowledges the beat again. A no-retry mode, latched at start, removes the window, so read beats are delivered just as write beats are.

The states are Idle, Transfer, Last-check, Last-redo and Turnaround. Idle goes to Transfer on start. Transfer goes to Last-check on the final read acknowledge in window mode. Transfer goes to Turnaround on the final acknowledge otherwise, or on an error. Transfer goes to Idle on address retry. Last-check goes to Last-redo on a retry, or back to Idle on a clean window or an error. Last-redo goes to Last-check on a new acknowledge, or to Idle on an error. Turnaround always returns to Idle.

Top module: `tenure_term_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy, beat-valid, done, error, machine-check and checkstop are all low.
- R2: A start pulse is taken only in Idle, and busy is high from the next cycle. A start while a tenure is open has no effect on the outputs.
- R3: A start count of 0 is treated as one beat, and a count above MAX_BEATS is treated as MAX_BEATS.
- R4: For writes, and for reads in no-retry mode, an acknowledge while busy gives beat-valid in the next cycle. The final acknowledge also gives done in that cycle, with busy low there, and Idle follows one cycle later. The slave may withhold the acknowledge for any number of cycles.
- R5: A read acknowledge in window mode gives beat-valid two cycles later if no data retry arrives in the cycle after the acknowledge.
- R6: A data retry in the window after a non-final read acknowledge voids that beat, and the beat count stays the same. An acknowledge in that same cycle is the repeat of the voided beat.
- R7: After the final read acknowledge in window mode, busy drops in the next cycle. If a data retry arrives in that cycle, busy stays low and done is held back until a new acknowledge passes its own window.
- R8: Data retry has no effect on write tenures or in no-retry mode.
- R9: A transfer error while busy gives an error pulse in the next cycle, with busy low and no done. A mid-burst error ends the tenure, and any further acknowledges are ignored.
- R10: A transfer error in the window after the final read acknowledge in window mode gives an error pulse and no done. After a final write or no-retry acknowledge it is ignored.
- R11: Each error pulse appears on exactly one of machine-check (enable high at the error) or checkstop (enable low).
- R12: An address retry while busy, with no transfer error, ends the tenure in the next cycle with busy low and no done, no error and no beat-valid.
- R13: Done and error are one-cycle pulses and never appear together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Tenure start pulse |
| start_beats_i | input | CNT_W | Beat count for the tenure |
| start_rd_i | input | 1 | 1 = read tenure, 0 = write |
| no_retry_i | input | 1 | No-retry mode, latched at start |
| mchk_en_i | input | 1 | Error routing: 1 = machine-check, 0 = checkstop |
| ack_i | input | 1 | Transfer acknowledge |
| dretry_i | input | 1 | Data retry |
| terr_i | input | 1 | Transfer error |
| aretry_i | input | 1 | Address retry |
| busy_o | output | 1 | Data bus busy |
| beat_valid_o | output | 1 | One beat delivered to the core |
| done_o | output | 1 | Tenure completed pulse |
| err_o | output | 1 | Tenure error pulse |
| mchk_o | output | 1 | Machine-check request pulse |
| cstop_o | output | 1 | Checkstop request pulse |

## Verification
The bench targets retries that land on the final read beat after busy has dropped. A design that finished too early would pulse done with busy low and skip the repeat acknowledge. It targets an acknowledge that coincides with a retry. Counting that acknowledge as a new beat would end the burst one beat short. It targets errors in the window after the final read beat, where a design that closed the tenure at busy-low would miss the error. It also checks that the window vanishes in no-retry mode and on writes. Each case is compared cycle by cycle against a behavioural model, along with a long randomised stream of overlapping terminations.

// File: rtl/tenure_pkg.sv
package tenure_pkg;

    typedef enum logic [2:0] {
        TS_IDLE      = 3'd0,
        TS_XFER      = 3'd1,
        TS_LAST_CHK  = 3'd2,
        TS_LAST_REDO = 3'd3,
        TS_TURN      = 3'd4
    } ten_state_e;

endpackage

// File: rtl/tenure_beat_cnt.sv
module tenure_beat_cnt #(
    parameter int MAX_BEATS = 4,
    parameter int CNT_W     = $clog2(MAX_BEATS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] rem_o
);

    localparam logic [CNT_W-1:0] MaxCnt = CNT_W'(MAX_BEATS);
    localparam logic [CNT_W-1:0] OneCnt = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] clamped;

    // zero counts as one beat, oversize counts clamp to the maximum
    always_comb begin
        if (load_val_i == '0)
            clamped = OneCnt;
        else if (load_val_i > MaxCnt)
            clamped = MaxCnt;
        else
            clamped = load_val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rem_q <= '0;
        else if (load_i)
            rem_q <= clamped;
        else
            rem_q <= rem_q + CNT_W'(inc_i) - CNT_W'(dec_i);
    end

    assign rem_o = rem_q;

endmodule

// File: rtl/tenure_err_route.sv
module tenure_err_route (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic mchk_en_i,
    output logic err_o,
    output logic mchk_o,
    output logic cstop_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o   <= 1'b0;
            mchk_o  <= 1'b0;
            cstop_o <= 1'b0;
        end else begin
            err_o   <= fire_i;
            mchk_o  <= fire_i && mchk_en_i;
            cstop_o <= fire_i && !mchk_en_i;
        end
    end

endmodule

// File: rtl/tenure_fsm.sv
module tenure_fsm
    import tenure_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             start_rd_i,
    input  logic             no_retry_i,
    input  logic             ack_i,
    input  logic             dretry_i,
    input  logic             terr_i,
    input  logic             aretry_i,
    input  logic [CNT_W-1:0] rem_i,
    output logic             cnt_load_o,
    output logic             cnt_inc_o,
    output logic             cnt_dec_o,
    output logic             busy_o,
    output logic             beat_valid_o,
    output logic             done_o,
    output logic             err_fire_o
);

    localparam logic [CNT_W-1:0] OneCnt = CNT_W'(1);

    ten_state_e st_q, st_d;
    logic       pend_q, pend_d;
    logic       rd_q, nr_q;
    logic       bv_d, done_d;
    logic       win_mode;
    logic       retry_hit;
    logic [CNT_W-1:0] eff_rem;
    logic       last_ack;

    assign win_mode  = rd_q && !nr_q;
    assign retry_hit = win_mode && pend_q && dretry_i;
    assign eff_rem   = rem_i + CNT_W'(retry_hit);
    assign last_ack  = (eff_rem == OneCnt);

    // state and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= TS_IDLE;
            pend_q <= 1'b0;
            rd_q   <= 1'b0;
            nr_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
            if (st_q == TS_IDLE && start_i) begin
                rd_q <= start_rd_i;
                nr_q <= no_retry_i;
            end
        end
    end

    // next state and pulse decisions
    always_comb begin
        st_d       = st_q;
        pend_d     = pend_q;
        cnt_load_o = 1'b0;
        cnt_inc_o  = 1'b0;
        cnt_dec_o  = 1'b0;
        bv_d       = 1'b0;
        done_d     = 1'b0;
        err_fire_o = 1'b0;
        unique case (st_q)
            TS_IDLE: begin
                pend_d = 1'b0;
                if (start_i) begin
                    cnt_load_o = 1'b1;
                    st_d       = TS_XFER;
                end
            end
            TS_XFER: begin
                // an earlier read beat clears its window unless retried
                bv_d = win_mode && pend_q && !dretry_i;
                if (terr_i) begin
                    err_fire_o = 1'b1;
                    pend_d     = 1'b0;
                    st_d       = TS_TURN;
                end else if (aretry_i) begin
                    bv_d   = 1'b0;
                    pend_d = 1'b0;
                    st_d   = TS_IDLE;
                end else begin
                    cnt_inc_o = retry_hit;
                    if (ack_i) begin
                        cnt_dec_o = 1'b1;
                        if (win_mode) begin
                            pend_d = 1'b1;
                            if (last_ack)
                                st_d = TS_LAST_CHK;
                        end else begin
                            bv_d   = 1'b1;
                            pend_d = 1'b0;
                            if (last_ack) begin
                                done_d = 1'b1;
                                st_d   = TS_TURN;
                            end
                        end
                    end else begin
                        pend_d = 1'b0;
                    end
                end
            end
            TS_LAST_CHK: begin
                pend_d = 1'b0;
                if (terr_i) begin
                    err_fire_o = 1'b1;
                    bv_d       = !dretry_i;
                    st_d       = TS_IDLE;
                end else if (dretry_i) begin
                    cnt_inc_o = 1'b1;
                    if (ack_i)
                        cnt_dec_o = 1'b1;
                    else
                        st_d = TS_LAST_REDO;
                end else begin
                    bv_d   = 1'b1;
                    done_d = 1'b1;
                    st_d   = TS_IDLE;
                end
            end
            TS_LAST_REDO: begin
                pend_d = 1'b0;
                if (terr_i) begin
                    err_fire_o = 1'b1;
                    st_d       = TS_IDLE;
                end else if (ack_i) begin
                    cnt_dec_o = 1'b1;
                    st_d      = TS_LAST_CHK;
                end
            end
            TS_TURN: begin
                pend_d = 1'b0;
                st_d   = TS_IDLE;
            end
            default: begin
                pend_d = 1'b0;
                st_d   = TS_IDLE;
            end
        endcase
    end

    // registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_valid_o <= 1'b0;
            done_o       <= 1'b0;
        end else begin
            beat_valid_o <= bv_d;
            done_o       <= done_d;
        end
    end

    assign busy_o = (st_q == TS_XFER);

endmodule

// File: rtl/tenure_term_ctrl.sv
module tenure_term_ctrl #(
    parameter int MAX_BEATS = 4,
    parameter int CNT_W     = $clog2(MAX_BEATS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] start_beats_i,
    input  logic             start_rd_i,
    input  logic             no_retry_i,
    input  logic             mchk_en_i,
    input  logic             ack_i,
    input  logic             dretry_i,
    input  logic             terr_i,
    input  logic             aretry_i,
    output logic             busy_o,
    output logic             beat_valid_o,
    output logic             done_o,
    output logic             err_o,
    output logic             mchk_o,
    output logic             cstop_o
);

    logic             cnt_load, cnt_inc, cnt_dec;
    logic [CNT_W-1:0] rem;
    logic             err_fire;

    tenure_beat_cnt #(
        .MAX_BEATS (MAX_BEATS),
        .CNT_W     (CNT_W)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (start_beats_i),
        .inc_i      (cnt_inc),
        .dec_i      (cnt_dec),
        .rem_o      (rem)
    );

    tenure_fsm #(
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_rd_i   (start_rd_i),
        .no_retry_i   (no_retry_i),
        .ack_i        (ack_i),
        .dretry_i     (dretry_i),
        .terr_i       (terr_i),
        .aretry_i     (aretry_i),
        .rem_i        (rem),
        .cnt_load_o   (cnt_load),
        .cnt_inc_o    (cnt_inc),
        .cnt_dec_o    (cnt_dec),
        .busy_o       (busy_o),
        .beat_valid_o (beat_valid_o),
        .done_o       (done_o),
        .err_fire_o   (err_fire)
    );

    tenure_err_route route_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (err_fire),
        .mchk_en_i (mchk_en_i),
        .err_o     (err_o),
        .mchk_o    (mchk_o),
        .cstop_o   (cstop_o)
    );

endmodule

// File: rtl/tenure_term_chk.sv
module tenure_term_chk (
    input logic clk,
    input logic rst_n,
    input logic mchk_en_i,
    input logic terr_i,
    input logic aretry_i,
    input logic busy_o,
    input logic done_o,
    input logic err_o,
    input logic mchk_o,
    input logic cstop_o
);

    AST_TERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && terr_i |=> !busy_o && err_o && !done_o); // R9

    AST_ARETRY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && aretry_i && !terr_i |=> !busy_o && !done_o && !err_o); // R12

    AST_ROUTE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (mchk_o != cstop_o)); // R11

    AST_ROUTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> !mchk_o && !cstop_o); // R11

    AST_ROUTE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (mchk_o == $past(mchk_en_i))); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R13

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R13

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R4

endmodule

bind tenure_term_ctrl tenure_term_chk chk_i (.*);

// File: tb/tenure_term_ctrl_tb_top.sv
module tenure_term_ctrl_tb_top;

    localparam int MAXB = 4;
    localparam int CW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] start_beats_i = '0;
    logic          start_rd_i = 1'b0;
    logic          no_retry_i = 1'b0;
    logic          mchk_en_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          dretry_i = 1'b0;
    logic          terr_i = 1'b0;
    logic          aretry_i = 1'b0;
    logic          busy_o, beat_valid_o, done_o, err_o, mchk_o, cstop_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    tenure_term_ctrl #(.MAX_BEATS(MAXB)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_beats_i(start_beats_i),
        .start_rd_i(start_rd_i), .no_retry_i(no_retry_i), .mchk_en_i(mchk_en_i),
        .ack_i(ack_i), .dretry_i(dretry_i), .terr_i(terr_i), .aretry_i(aretry_i),
        .busy_o(busy_o), .beat_valid_o(beat_valid_o), .done_o(done_o),
        .err_o(err_o), .mchk_o(mchk_o), .cstop_o(cstop_o)
    );

    // behavioural reference: phase 0 idle, 1 busy, 2 final window, 3 waiting repeat, 4 gap
    int phase = 0;
    int owed  = 0;
    bit waiting = 0;
    bit m_rd = 0, m_nr = 0;
    bit e_busy = 0, e_bv = 0, e_done = 0, e_err = 0, e_mc = 0, e_cs = 0;

    task automatic raise_err();
        e_err = 1; e_mc = mchk_en_i; e_cs = !mchk_en_i;
    endtask

    always @(posedge clk) begin
        bit windowed;
        e_bv = 0; e_done = 0; e_err = 0; e_mc = 0; e_cs = 0;
        if (!rst_n) begin
            phase = 0; owed = 0; waiting = 0;
        end else begin
            windowed = m_rd && !m_nr;
            case (phase)
                0: if (start_i) begin
                    owed = (start_beats_i == 0) ? 1 : ((start_beats_i > MAXB) ? MAXB : int'(start_beats_i));
                    m_rd = start_rd_i; m_nr = no_retry_i; waiting = 0; phase = 1;
                end
                1: begin
                    if (windowed && waiting && !dretry_i) e_bv = 1;
                    if (terr_i) begin
                        raise_err(); phase = 4; waiting = 0;
                    end else if (aretry_i) begin
                        e_bv = 0; phase = 0; waiting = 0;
                    end else begin
                        if (windowed && waiting && dretry_i) owed++;
                        if (ack_i) begin
                            owed--;
                            if (windowed) begin
                                waiting = 1;
                                if (owed == 0) phase = 2;
                            end else begin
                                e_bv = 1;
                                if (owed == 0) begin e_done = 1; phase = 4; end
                            end
                        end else waiting = 0;
                    end
                end
                2: begin
                    if (terr_i) begin
                        raise_err(); e_bv = !dretry_i; phase = 0;
                    end else if (dretry_i) begin
                        if (!ack_i) phase = 3;
                    end else begin
                        e_bv = 1; e_done = 1; phase = 0;
                    end
                end
                3: begin
                    if (terr_i) begin raise_err(); phase = 0; end
                    else if (ack_i) phase = 2;
                end
                default: phase = 0;
            endcase
        end
        e_busy = (phase == 1);
    end

    // compare on every falling edge
    always @(negedge clk) begin
        logic [5:0] act, exp_v;
        act   = {busy_o, beat_valid_o, done_o, err_o, mchk_o, cstop_o};
        exp_v = {e_busy, e_bv, e_done, e_err, e_mc, e_cs};
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s t=%0t {busy,bv,done,err,mc,cs} act=%b exp=%b", cur_req, $time, act, exp_v);
        end
    end

    task automatic step(input bit s, input int b, input bit rd, input bit a,
                        input bit dr, input bit te, input bit ar);
        start_i = s; start_beats_i = CW'(b); start_rd_i = rd;
        ack_i = a; dretry_i = dr; terr_i = te; aretry_i = ar;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        cur_req = "R1";
        n_tests++;
        if ({busy_o, beat_valid_o, done_o, err_o, mchk_o, cstop_o} !== 6'b0) begin
            n_fail++;
            $display("FAIL R1 reset act=%b exp=000000",
                     {busy_o, beat_valid_o, done_o, err_o, mchk_o, cstop_o});
        end
        rst_n = 1'b1;
        idle(2);

        // R4: write burst with withheld acks; R2 start while busy ignored
        cur_req = "R4";
        step(1, 4, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        cur_req = "R2";
        step(1, 1, 1, 0, 0, 0, 0);
        cur_req = "R4";
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        idle(3);

        // R3: zero and oversize counts
        cur_req = "R3";
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        idle(2);
        step(1, 7, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 0, 0);
        idle(3);

        // R5: clean read burst, back-to-back acks
        cur_req = "R5";
        step(1, 4, 1, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 0);
        idle(4);

        // R6: retry mid burst, retry with coincident ack
        cur_req = "R6";
        step(1, 3, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        idle(3);

        // R7: retry of the final read beat after busy drops
        cur_req = "R7";
        step(1, 2, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        idle(3);

        // R8: retry ignored on writes and in no-retry mode
        cur_req = "R8";
        step(1, 2, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        idle(2);
        no_retry_i = 1'b1;
        step(1, 2, 1, 0, 0, 0, 0);
        no_retry_i = 1'b0;
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        idle(3);

        // R9 and R11: mid-burst errors on both routes
        cur_req = "R9";
        mchk_en_i = 1'b1;
        step(1, 4, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 1, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        idle(2);
        cur_req = "R11";
        mchk_en_i = 1'b0;
        step(1, 4, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        idle(3);

        // R10: error in final read window, then ignored cases
        cur_req = "R10";
        mchk_en_i = 1'b1;
        step(1, 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        idle(2);
        no_retry_i = 1'b1;
        step(1, 1, 1, 0, 0, 0, 0);
        no_retry_i = 1'b0;
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        idle(2);
        step(1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        idle(3);

        // R12: address retry aborts, drops pending read beat
        cur_req = "R12";
        step(1, 4, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        idle(2);
        step(1, 3, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 1);
        idle(3);

        // R13: randomised overlapping terminations
        cur_req = "R13";
        for (int i = 0; i < 4000; i++) begin
            mchk_en_i  = 1'($urandom_range(0, 1));
            no_retry_i = ($urandom_range(0, 3) == 0);
            step($urandom_range(0, 3) == 0, $urandom_range(0, 7), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 4) == 0,
                 $urandom_range(0, 30) == 0, $urandom_range(0, 30) == 0);
        end
        idle(4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule